// File: doc/BRIEF.md
# Parallel-Gated Channel Enable Stage

This block produces the final on/off command for eight low-side output channels. A command register holds one bit per channel, loaded in a single cycle by a write strobe from the serial front end. The lower four channels also have a direct pin input, intended for pulse-width modulation. The upper four channels follow their command bit alone.

For each of the lower four channels, the pin input is first reduced to an "active" level according to a polarity select. The channel is on only when that active level and the channel's command bit are both set. A command bit of zero therefore forces the channel off, whatever its pin does. This lets software disable a channel whose pin is tied permanently active, for example to run diagnostics with the channel off.

The pin path has two further features. Each pin input carries a driven flag, and an undriven pin resolves to the inactive level for the current polarity. An undriven polarity select resolves to active high. The resolved levels then pass through a two-flop synchroniser before the gate. The active-low asynchronous reset clears the command register and the synchroniser, so all eight channels stay off until a command is written.

Top module: `pgate_out_gating`

## Requirements
- R1: While `rst_ni` is low, `en_o` is 8'h00. After reset is released, `en_o` stays 8'h00 until a command write, whatever the pin inputs are.
- R2: A rising clock edge with `cmd_we_i` high loads `cmd_bits_i` into the command register. Bit k of the register is channel k, and bit 0 is the first pin-gated channel. With `cmd_we_i` low, the register keeps its value.
- R3: `en_o[7:4]` equals command bits 7 to 4, and no pin, polarity or driven-flag input changes them.
- R4: For k in 0..3, `en_o[k]` is high only when command bit k is 1 and pin k is at its active level.
- R5: With `pol_drv_i`=1 and `pol_i`=1, a driven pin is active when `par_i[k]`=1.
- R6: With `pol_drv_i`=1 and `pol_i`=0, a driven pin is active when `par_i[k]`=0.
- R7: With `pol_drv_i`=0, pins are treated as active high, and the value on `pol_i` is ignored.
- R8: A pin with `par_drv_i[k]`=0 is inactive under either polarity, whatever the value on `par_i[k]`.
- R9: A change on the pin, driven-flag or polarity inputs reaches `en_o` after exactly two rising edges. A command write reaches `en_o` after one rising edge.
- R10: A command bit of 0 keeps its channel off even while its pin is held active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_bits_i | input | 8 | Command bits, one per channel |
| par_i | input | 4 | Direct pin inputs for channels 0..3 |
| par_drv_i | input | 4 | Driven flag per pin input; 0 means the pin is floating |
| pol_i | input | 1 | Polarity select; 1 = active high, 0 = active low |
| pol_drv_i | input | 1 | Driven flag for the polarity select |
| en_o | output | 8 | Final channel enable vector |

## Verification
The assertions check several rules on every cycle:
- reset forces all enables off;
- the command register loads on a write and holds otherwise;
- the upper channels follow their written bit;
- a written zero vetoes a lower channel;
- a floating pin never resolves active, and each polarity case maps a driven pin correctly;
- the synchroniser output lags its input by two edges.

Some behaviours only the bench scenarios can show. One is that an enable stays low after reset until a write arrives. Another is the full end-to-end latency seen at `en_o`. A third is that all four combinations of polarity and floating pin leave the channel off.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam int unsigned N_CH_DEF  = 8;
  localparam int unsigned N_PAR_DEF = 4;
  localparam int unsigned SYNC_DEF  = 2;

  function automatic logic pin_active(input logic lvl, input logic pol);
    return ~(lvl ^ pol);
  endfunction
endpackage

// File: rtl/pgate_cmd_latch.sv
module pgate_cmd_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= d_i;
  end

  assign q_o = q_q;

  AST_CMD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i)); // R2
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R2
endmodule

// File: rtl/pgate_pin_resolve.sv
module pgate_pin_resolve #(
  parameter int unsigned W            = 4,
  parameter logic        POL_UNDRIVEN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] drv_i,
  input  logic         pol_i,
  input  logic         pol_drv_i,
  output logic [W-1:0] act_o
);
  import pgate_pkg::*;

  logic pol_eff;
  assign pol_eff = pol_drv_i ? pol_i : POL_UNDRIVEN;

  for (genvar k = 0; k < W; k++) begin : g_pin
    logic lvl;
    // floating pin settles at the inactive level for the current polarity
    assign lvl      = drv_i[k] ? pin_i[k] : ~pol_eff;
    assign act_o[k] = pin_active(lvl, pol_eff);

    AST_FLOAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drv_i[k] |-> !act_o[k]); // R8
    AST_POL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_i[k] && pol_drv_i && pol_i) |-> (act_o[k] == pin_i[k])); // R5
    AST_POL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_i[k] && pol_drv_i && !pol_i) |-> (act_o[k] != pin_i[k])); // R6
    AST_POL_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_i[k] && !pol_drv_i) |-> (act_o[k] == pin_i[k])); // R7
  end
endmodule

// File: rtl/pgate_sync.sv
module pgate_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];

  if (STAGES == 2) begin : g_chk2
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2) |-> (q_o == $past(d_i, 2))); // R9
  end
endmodule

// File: rtl/pgate_out_gating.sv
module pgate_out_gating #(
  parameter int unsigned N_CH         = pgate_pkg::N_CH_DEF,
  parameter int unsigned N_PAR        = pgate_pkg::N_PAR_DEF,
  parameter int unsigned SYNC_STAGES  = pgate_pkg::SYNC_DEF,
  parameter logic        POL_UNDRIVEN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [N_CH-1:0]  cmd_bits_i,
  input  logic [N_PAR-1:0] par_i,
  input  logic [N_PAR-1:0] par_drv_i,
  input  logic             pol_i,
  input  logic             pol_drv_i,
  output logic [N_CH-1:0]  en_o
);
  logic [N_CH-1:0]  cmd_q;
  logic [N_PAR-1:0] act_raw;
  logic [N_PAR-1:0] act_sync;

  pgate_cmd_latch #(.W(N_CH)) i_cmd_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cmd_we_i),
    .d_i    (cmd_bits_i),
    .q_o    (cmd_q)
  );

  pgate_pin_resolve #(.W(N_PAR), .POL_UNDRIVEN(POL_UNDRIVEN)) i_pin_resolve (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (par_i),
    .drv_i     (par_drv_i),
    .pol_i     (pol_i),
    .pol_drv_i (pol_drv_i),
    .act_o     (act_raw)
  );

  pgate_sync #(.W(N_PAR), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (act_raw),
    .q_o    (act_sync)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    if (c < N_PAR) begin : g_gated
      assign en_o[c] = cmd_q[c] & act_sync[c];
    end else begin : g_direct
      assign en_o[c] = cmd_q[c];
    end
  end

  // first edge after reset release marks history as valid
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_RST_OFF: assert property (@(posedge clk_i)
    !rst_ni |-> (en_o == '0)); // R1

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    AST_SER_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(cmd_we_i) && !$past(cmd_bits_i[c])) |-> !en_o[c]); // R10
    if (c >= N_PAR) begin : g_up
      AST_UPPER_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(cmd_we_i)) |-> (en_o[c] == $past(cmd_bits_i[c]))); // R3
    end
  end
endmodule

// File: tb/test_pgate_out_gating.sv
module test_pgate_out_gating;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_we;
  logic [7:0] cmd_bits;
  logic [3:0] par, par_drv;
  logic       pol, pol_drv;
  logic [7:0] en;

  pgate_out_gating i_pgate_out_gating (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmd_we_i   (cmd_we),
    .cmd_bits_i (cmd_bits),
    .par_i      (par),
    .par_drv_i  (par_drv),
    .pol_i      (pol),
    .pol_drv_i  (pol_drv),
    .en_o       (en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] m_cmd = 8'h00;

  function automatic logic [7:0] model_en();
    logic pe;
    logic [3:0] act;
    pe = pol_drv ? pol : 1'b1;
    for (int k = 0; k < 4; k++) act[k] = par_drv[k] && (par[k] == pe);
    return {m_cmd[7:4], m_cmd[3:0] & act};
  endfunction

  task automatic push(input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares each expected item against en_o when it is posted
  initial forever begin
    item_t it;
    wait (sb_q.size() > 0);
    it = sb_q.pop_front();
    n_chk++;
    if (en !== it.exp) begin
      n_err++;
      $display("FAIL %s: en_o=%h expected %h", it.tag, en, it.exp);
    end
  end

  task automatic write_cmd(input logic [7:0] b, input string tag);
    @(negedge clk); cmd_we = 1'b1; cmd_bits = b;
    @(negedge clk); cmd_we = 1'b0; cmd_bits = ~b;
    m_cmd = b;
    push(model_en(), tag);
  endtask

  // drives pin side, checks old value after one edge and new after two
  task automatic set_pins(input logic [3:0] p, input logic [3:0] d,
                          input logic pl, input logic pd, input string tag);
    logic [7:0] old_v;
    old_v = model_en();
    @(negedge clk); par = p; par_drv = d; pol = pl; pol_drv = pd;
    @(negedge clk); push(old_v, {tag, " R9 one edge"});
    @(negedge clk); push(model_en(), tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: en_o=%h expected completion", en);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; cmd_bits = 8'hFF;
    par = 4'hF; par_drv = 4'hF; pol = 1'b1; pol_drv = 1'b1;
    repeat (2) @(negedge clk);
    push(8'h00, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push(8'h00, "R1 after release");

    write_cmd(8'hFF, "R2 R4 R9 write all");
    set_pins(4'h0, 4'hF, 1'b1, 1'b1, "R5 R3 pins low act-high");
    set_pins(4'hA, 4'hF, 1'b1, 1'b1, "R5 pattern A");
    set_pins(4'h5, 4'hF, 1'b0, 1'b1, "R6 act-low pattern 5");
    set_pins(4'hF, 4'hF, 1'b0, 1'b1, "R6 act-low all high");
    set_pins(4'hF, 4'hF, 1'b0, 1'b0, "R7 undriven pol, pins high");
    set_pins(4'h0, 4'hF, 1'b0, 1'b0, "R7 undriven pol, pins low");

    for (int pl = 0; pl < 2; pl++)
      for (int pv = 0; pv < 2; pv++)
        set_pins({4{pv[0]}}, 4'h0, pl[0], 1'b1, "R8 floating pins");
    set_pins(4'h3, 4'h6, 1'b1, 1'b1, "R8 partial float");

    set_pins(4'hF, 4'hF, 1'b1, 1'b1, "R4 all active");
    write_cmd(8'h30, "R10 R3 zero veto");
    write_cmd(8'hA5, "R2 R4 write A5");
    set_pins(4'h0, 4'hF, 1'b1, 1'b1, "R3 upper ignores pins");
    set_pins(4'hF, 4'h0, 1'b0, 1'b0, "R3 upper ignores float");

    @(negedge clk); cmd_bits = 8'h00;
    repeat (3) @(negedge clk);
    push(model_en(), "R2 hold without write");

    @(negedge clk); rst_n = 1'b0; m_cmd = 8'h00;
    #1 push(8'h00, "R1 async reset mid-run");
    @(negedge clk); rst_n = 1'b1; par = 4'hF; par_drv = 4'hF; pol = 1'b1; pol_drv = 1'b1;
    repeat (4) @(negedge clk);
    push(8'h00, "R1 off until write");
    write_cmd(8'h0F, "R4 R9 lower only");

    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule